// File: doc/BRIEF.md
# Global Control and Status Register Block

This block gives a host processor two 8-bit registers for chip-wide housekeeping. The control register at address 0xF00 turns host writes into single-cycle command pulses for three external engines: the configuration store to an I2C EEPROM, the built-in self-test (BIST) of the on-chip RAM, and the chip reset generator. The same register holds an initialization-complete flag that drives an output pin. The status register at 0xF01 is read-only. It combines live busy flags from the EEPROM and BIST engines and the RAM test result with a fixed device signature and a revision code.

Two commands, configuration store and BIST start, act on the falling edge of their control bit. The host arms them by writing 1 and fires them by a later write of 0. Soft reset and store-then-reset act on a plain write of 1. Store-then-reset issues the store at once. It then holds the reset request back until the EEPROM engine has been seen busy and has gone idle again. A mode input selects managed or unmanaged operation. In unmanaged operation the initialization flag is reserved and cannot be set.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the control register reads 0x00, `initDone` is low, and no command output is high.
- R2: A read at 0xF01 returns the following fields: bit 0 `eeWrBusy`, bit 1 `eeRdBusy`, bit 2 `bistBusy`, bit 3 `ramErr`, bits 5:4 the constant 2'b10, and bits 7:6 the parameter `REV`. A read at any address other than 0xF00 or 0xF01 returns 0x00. Read data is combinational in `cpuAddr`.
- R3: A write to 0xF00 with bit 0 = 0, while the stored bit 0 is 1, raises `storeCmd` for exactly the one cycle after the write edge. A write with bit 0 = 1, or a write of 0 when bit 0 is already 0, raises nothing.
- R4: A write to 0xF00 with bit 2 = 0, while the stored bit 2 is 1, raises `bistStartCmd` for exactly the one cycle after the write edge. Other writes to bit 2 raise nothing.
- R5: A write of 1 to bit 1 of 0xF00 when no store-then-reset is pending raises `storeCmd` in the cycle after the write edge, and bit 1 then reads 1. `chipResetReq` stays low until `eeWrBusy` has been sampled high and then sampled low. It is then high for exactly the cycle after the edge that sampled `eeWrBusy` low.
- R6: A write of 1 to bit 3 of 0xF00 raises `chipResetReq` for the cycle after the write edge. That write raises no other command and cancels a pending store-then-reset. Whenever `chipResetReq` is high, the control register reads 0x00 and `initDone` is low.
- R7: When `managedMode` is 1, a write of 1 to bit 4 sets the flag, and `initDone` goes high the cycle after the write edge. A later write of 0 leaves the flag set. Only a reset request clears it. When `managedMode` is 0, bit 4 of a write is ignored.
- R8: A write to 0xF01, or to any address other than 0xF00, changes no control bit and raises no command.
- R9: Bits 7:5 of the control register always read 0, and bit 3 reads 0 after every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| managedMode | input | 1 | 1 = managed operation (initialization flag usable) |
| cpuAddr | input | ADDR_W | Host register address |
| cpuWrEn | input | 1 | Host write enable, sampled at the clock edge |
| cpuWrData | input | 8 | Host write data |
| cpuRdData | output | 8 | Host read data for `cpuAddr` |
| eeWrBusy | input | 1 | EEPROM engine is writing configuration |
| eeRdBusy | input | 1 | EEPROM engine is reading configuration |
| bistBusy | input | 1 | Self-test is running |
| ramErr | input | 1 | Self-test found a RAM error |
| storeCmd | output | 1 | One-cycle pulse that starts a configuration store |
| bistStartCmd | output | 1 | One-cycle pulse that starts the self-test |
| chipResetReq | output | 1 | One-cycle chip reset request |
| initDone | output | 1 | Initialization-complete pin |

## Verification
All command pulses and `initDone` come from registers. Each is due in the cycle that follows the clock edge that samples the write. The bench drives a write half a cycle before that edge and checks the outputs at the next falling edge. It then checks again one falling edge later to confirm the pulse has ended. Register reads are combinational, so they are checked half a nanosecond after the address changes, within the same cycle. The reset request of store-then-reset is due one cycle after the edge that samples `eeWrBusy` low. Before that edge the bench confirms at every falling edge that the request is still low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 5;

  // Control bit positions (host-visible layout)
  localparam int CB_STORE     = 0;
  localparam int CB_STORE_RST = 1;
  localparam int CB_BIST      = 2;
  localparam int CB_SOFT      = 3;
  localparam int CB_INIT      = 4;

  localparam logic [1:0] DEV_SIG = 2'b10;

  typedef enum logic [1:0] {
    SR_IDLE      = 2'd0,
    SR_WAIT_RISE = 2'd1,
    SR_WAIT_FALL = 2'd2
  } srState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctrlWr;
    logic clearAll;
    logic initSet;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [1:0] rev;
    logic [1:0] sig;
    logic       ramErr;
    logic       bistBusy;
    logic       eeRdBusy;
    logic       eeWrBusy;
  } statusWord_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              managedMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic              eeWrBusy,
  input  logic              armStore,
  input  logic              armBist,
  output ctrlStrobe_t       strb,
  output logic              storeCmd,
  output logic              bistStartCmd,
  output logic              chipResetReq
);

  logic     ctrlWr;
  logic     softHit;
  logic     resetFire;
  logic     clearAll;
  logic     wrLive;
  logic     storeFall;
  logic     bistFall;
  logic     storeRstHit;
  srState_e srQ;
  srState_e srD;

  assign ctrlWr      = cpuWrEn && (cpuAddr == CTRL_ADDR);
  assign softHit     = ctrlWr && wrBits[CB_SOFT];
  assign resetFire   = (srQ == SR_WAIT_FALL) && !eeWrBusy;
  assign clearAll    = softHit || resetFire;
  assign wrLive      = ctrlWr && !clearAll;

  assign storeFall   = wrLive && armStore && !wrBits[CB_STORE];
  assign bistFall    = wrLive && armBist  && !wrBits[CB_BIST];
  assign storeRstHit = wrLive && wrBits[CB_STORE_RST] && (srQ == SR_IDLE);

  assign strb.ctrlWr   = ctrlWr;
  assign strb.clearAll = clearAll;
  assign strb.initSet  = wrLive && managedMode && wrBits[CB_INIT];

  // Store-then-reset sequencer
  always_comb begin
    srD = srQ;
    unique case (srQ)
      SR_IDLE:      if (storeRstHit) srD = SR_WAIT_RISE;
      SR_WAIT_RISE: if (eeWrBusy)    srD = SR_WAIT_FALL;
      SR_WAIT_FALL: if (!eeWrBusy)   srD = SR_IDLE;
      default:                       srD = SR_IDLE;
    endcase
    if (softHit) srD = SR_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ          <= SR_IDLE;
      storeCmd     <= 1'b0;
      bistStartCmd <= 1'b0;
      chipResetReq <= 1'b0;
    end else begin
      srQ          <= srD;
      storeCmd     <= storeFall || storeRstHit;
      bistStartCmd <= bistFall;
      chipResetReq <= clearAll;
    end
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'hF01,
  parameter logic [1:0]        REV       = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [2:0]        wrLow,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              eeWrBusy,
  input  logic              eeRdBusy,
  input  logic              bistBusy,
  input  logic              ramErr,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic              initDone,
  output logic [DATA_W-1:0] cpuRdData
);

  logic [CTRL_W-1:0] ctrlQ;
  statusWord_t       statW;

  // Written command bits 2:0 follow the write data directly
  for (genvar g = 0; g < 3; g++) begin : g_cmdBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              ctrlQ[g] <= 1'b0;
      else if (strb.clearAll) ctrlQ[g] <= 1'b0;
      else if (strb.ctrlWr)   ctrlQ[g] <= wrLow[g];
    end
  end

  // Soft-reset bit is self-clearing: never held at 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ[CB_SOFT] <= 1'b0;
    else       ctrlQ[CB_SOFT] <= 1'b0;
  end

  // Sticky initialization flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlQ[CB_INIT] <= 1'b0;
    else if (strb.clearAll) ctrlQ[CB_INIT] <= 1'b0;
    else if (strb.initSet)  ctrlQ[CB_INIT] <= 1'b1;
  end

  assign statW.rev      = REV;
  assign statW.sig      = DEV_SIG;
  assign statW.ramErr   = ramErr;
  assign statW.bistBusy = bistBusy;
  assign statW.eeRdBusy = eeRdBusy;
  assign statW.eeWrBusy = eeWrBusy;

  always_comb begin
    cpuRdData = '0;
    if (cpuAddr == CTRL_ADDR)      cpuRdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
    else if (cpuAddr == STAT_ADDR) cpuRdData = statW;
  end

  assign ctrlBits = ctrlQ;
  assign initDone = ctrlQ[CB_INIT];

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'hF01,
  parameter logic [1:0]        REV       = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              managedMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic [7:0]        cpuWrData,
  output logic [7:0]        cpuRdData,
  input  logic              eeWrBusy,
  input  logic              eeRdBusy,
  input  logic              bistBusy,
  input  logic              ramErr,
  output logic              storeCmd,
  output logic              bistStartCmd,
  output logic              chipResetReq,
  output logic              initDone
);

  ctrlStrobe_t       strb;
  logic [CTRL_W-1:0] ctrlBits;
  logic              unusedHiBits;

  assign unusedHiBits = ^cpuWrData[DATA_W-1:CTRL_W];

  sysctl_ctrl #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .managedMode  (managedMode),
    .cpuAddr      (cpuAddr),
    .cpuWrEn      (cpuWrEn),
    .wrBits       (cpuWrData[CTRL_W-1:0]),
    .eeWrBusy     (eeWrBusy),
    .armStore     (ctrlBits[CB_STORE]),
    .armBist      (ctrlBits[CB_BIST]),
    .strb         (strb),
    .storeCmd     (storeCmd),
    .bistStartCmd (bistStartCmd),
    .chipResetReq (chipResetReq)
  );

  sysctl_dp #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR),
    .REV       (REV)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrLow     (cpuWrData[2:0]),
    .cpuAddr   (cpuAddr),
    .eeWrBusy  (eeWrBusy),
    .eeRdBusy  (eeRdBusy),
    .bistBusy  (bistBusy),
    .ramErr    (ramErr),
    .ctrlBits  (ctrlBits),
    .initDone  (initDone),
    .cpuRdData (cpuRdData)
  );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'hF01
) (
  input logic              clk,
  input logic              rstN,
  input logic              managedMode,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWrEn,
  input logic [7:0]        cpuRdData,
  input logic [4:0]        ctrlBits,
  input logic              storeCmd,
  input logic              bistStartCmd,
  input logic              chipResetReq,
  input logic              initDone
);

  // R3 / R5: a store pulse always follows a host write
  a_r3_store_from_write: assert property (@(posedge clk) disable iff (!rstN)
    storeCmd |-> $past(cpuWrEn));

  // R4: self-test start never lasts two cycles
  a_r4_bist_single: assert property (@(posedge clk) disable iff (!rstN)
    bistStartCmd |=> !bistStartCmd);

  // R6: the register is empty while a reset request is out
  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    chipResetReq |-> (ctrlBits == 5'd0 && !initDone));

  // R7: unmanaged mode cannot raise the init pin
  a_r7_unmanaged_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!managedMode && !initDone) |=> !initDone);

  // R7: init pin is sticky until a reset request
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> (initDone || chipResetReq));

  // R9: reserved control bits read zero
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == CTRL_ADDR) |-> (cpuRdData[7:5] == 3'd0 && cpuRdData[3] == 1'b0));

  // R2: signature field constant
  a_r2_signature: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr == STAT_ADDR) |-> (cpuRdData[5:4] == 2'b10));

endmodule

bind sysctl_regs sysctl_regs_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .managedMode  (managedMode),
  .cpuAddr      (cpuAddr),
  .cpuWrEn      (cpuWrEn),
  .cpuRdData    (cpuRdData),
  .ctrlBits     (ctrlBits),
  .storeCmd     (storeCmd),
  .bistStartCmd (bistStartCmd),
  .chipResetReq (chipResetReq),
  .initDone     (initDone)
);

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;

  localparam logic [11:0] CTRL  = 12'hF00;
  localparam logic [11:0] STAT  = 12'hF01;
  localparam logic [11:0] OTHER = 12'h0A5;
  localparam logic [1:0]  REV   = 2'b01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        managedMode = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        eeWrBusy = 1'b0, eeRdBusy = 1'b0, bistBusy = 1'b0, ramErr = 1'b0;
  logic        storeCmd, bistStartCmd, chipResetReq, initDone;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sysctl_regs #(.REV(REV)) u0 (
    .clk(clk), .rstN(rstN), .managedMode(managedMode),
    .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .eeWrBusy(eeWrBusy), .eeRdBusy(eeRdBusy),
    .bistBusy(bistBusy), .ramErr(ramErr), .storeCmd(storeCmd),
    .bistStartCmd(bistStartCmd), .chipResetReq(chipResetReq),
    .initDone(initDone)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expStatus(input logic w, input logic r,
                                           input logic b, input logic e);
    return {REV, 2'b10, e, b, r, w};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic mm);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1; managedMode = mm;
    @(negedge clk);
    cpuWrEn = 1'b0; cpuWrData = '0;
  endtask

  task automatic rdCheck(input string req, input logic [11:0] a, input logic [7:0] exp);
    cpuAddr = a;
    #0.5;
    check(req, cpuRdData, exp);
  endtask

  task automatic pulses(input string req, input logic s, input logic b, input logic r);
    check({req, " storeCmd"},     {7'd0, storeCmd},     {7'd0, s});
    check({req, " bistStartCmd"}, {7'd0, bistStartCmd}, {7'd0, b});
    check({req, " chipResetReq"}, {7'd0, chipResetReq}, {7'd0, r});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] m;
    logic [7:0] d;
    logic       mm;
    logic       s, b, r;
    int         sel;
    logic [11:0] a;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdCheck("R1 ctrl after reset", CTRL, 8'h00);
    pulses("R1", 0, 0, 0);
    check("R1 initDone", {7'd0, initDone}, 8'h00);

    // R2 status layout and unmapped read
    eeWrBusy = 1; eeRdBusy = 0; bistBusy = 1; ramErr = 0;
    rdCheck("R2 status a", STAT, expStatus(1, 0, 1, 0));
    eeWrBusy = 0; eeRdBusy = 1; bistBusy = 0; ramErr = 1;
    rdCheck("R2 status b", STAT, expStatus(0, 1, 0, 1));
    rdCheck("R2 unmapped", OTHER, 8'h00);
    eeRdBusy = 0; ramErr = 0;

    // R3 store on 1->0
    wr(CTRL, 8'h01, 1'b1); pulses("R3 arm", 0, 0, 0);
    rdCheck("R3 armed", CTRL, 8'h01);
    wr(CTRL, 8'h00, 1'b1); pulses("R3 fire", 1, 0, 0);
    @(negedge clk);        pulses("R3 one cycle", 0, 0, 0);
    wr(CTRL, 8'h00, 1'b1); pulses("R3 no refire", 0, 0, 0);

    // R4 BIST on 1->0
    wr(CTRL, 8'h04, 1'b1); pulses("R4 arm", 0, 0, 0);
    wr(CTRL, 8'h04, 1'b1); pulses("R4 rewrite one", 0, 0, 0);
    wr(CTRL, 8'h00, 1'b1); pulses("R4 fire", 0, 1, 0);
    @(negedge clk);        pulses("R4 one cycle", 0, 0, 0);

    // R9 reserved bits
    wr(CTRL, 8'hE0, 1'b1);
    rdCheck("R9 reserved read", CTRL, 8'h00);

    // R7 init flag
    wr(CTRL, 8'h10, 1'b0);
    check("R7 unmanaged pin", {7'd0, initDone}, 8'h00);
    rdCheck("R7 unmanaged read", CTRL, 8'h00);
    wr(CTRL, 8'h10, 1'b1);
    check("R7 managed pin", {7'd0, initDone}, 8'h01);
    rdCheck("R7 managed read", CTRL, 8'h10);
    wr(CTRL, 8'h00, 1'b1);
    check("R7 sticky pin", {7'd0, initDone}, 8'h01);

    // R8 writes elsewhere ignored
    wr(STAT, 8'hFF, 1'b1); pulses("R8 status write", 0, 0, 0);
    rdCheck("R8 ctrl kept", CTRL, 8'h10);
    wr(OTHER, 8'h0F, 1'b1); pulses("R8 other write", 0, 0, 0);
    rdCheck("R8 ctrl kept 2", CTRL, 8'h10);

    // R6 soft reset
    wr(CTRL, 8'h0D, 1'b1);
    pulses("R6 soft", 0, 0, 1);
    check("R6 pin low", {7'd0, initDone}, 8'h00);
    rdCheck("R6 cleared", CTRL, 8'h00);
    @(negedge clk); pulses("R6 one cycle", 0, 0, 0);

    // R5 store then reset
    wr(CTRL, 8'h02, 1'b1);
    pulses("R5 store", 1, 0, 0);
    rdCheck("R5 bit1 reads 1", CTRL, 8'h02);
    repeat (3) begin @(negedge clk); pulses("R5 wait rise", 0, 0, 0); end
    eeWrBusy = 1'b1;
    repeat (4) begin @(negedge clk); pulses("R5 wait fall", 0, 0, 0); end
    eeWrBusy = 1'b0;
    @(negedge clk); pulses("R5 reset", 0, 0, 1);
    rdCheck("R5 cleared", CTRL, 8'h00);
    @(negedge clk); pulses("R5 one cycle", 0, 0, 0);

    // R6 soft reset cancels a pending store-then-reset
    wr(CTRL, 8'h02, 1'b1); pulses("R6 cancel store", 1, 0, 0);
    eeWrBusy = 1'b1;
    @(negedge clk);
    wr(CTRL, 8'h08, 1'b1); pulses("R6 cancel soft", 0, 0, 1);
    eeWrBusy = 1'b0;
    repeat (4) begin @(negedge clk); pulses("R6 no late reset", 0, 0, 0); end

    // Random mix (bit 1 left out so no sequence is pending)
    m = 8'h00;
    for (int i = 0; i < 400; i++) begin
      sel = int'($urandom % 4);
      a   = (sel < 2) ? CTRL : ((sel == 2) ? STAT : OTHER);
      d   = 8'($urandom) & 8'hFD;
      if (($urandom % 4) != 0) d[3] = 1'b0;
      mm  = 1'($urandom);
      s = 0; b = 0; r = 0;
      if (a == CTRL) begin
        if (d[3]) begin
          r = 1; m = 8'h00;
        end else begin
          s = m[0] && !d[0];
          b = m[2] && !d[2];
          m = {3'b000, m[4] | (mm & d[4]), 1'b0, d[2], 1'b0, d[0]};
        end
      end
      wr(a, d, mm);
      pulses((a == CTRL) ? "R3/R4/R6 random" : "R8 random", s, b, r);
      check("R7 random pin", {7'd0, initDone}, {7'd0, m[4]});
      rdCheck("R9 random ctrl", CTRL, m);
      eeWrBusy = 1'($urandom); eeRdBusy = 1'($urandom);
      bistBusy = 1'($urandom); ramErr = 1'($urandom);
      rdCheck("R2 random status", STAT, expStatus(eeWrBusy, eeRdBusy, bistBusy, ramErr));
      eeWrBusy = 1'b0;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule